// File: doc/BRIEF.md
# VBI Line Pass-Through Gate

The gate sits on the capture side of a video port. For every vertical-blanking-interval line it decides whether the line goes straight on to the TV output path, and it passes or drops the line's sample stream to match. Software sets two enable masks, one for odd fields and one for even fields, over a simple write-only register bus. Each mask has one bit per VBI line.

At each line-start strobe the gate samples the field parity and the line index. It looks up the enable bit in the mask for that parity and holds the result for the whole line. The masks only matter when direct-VBI mode is selected. With the mode off, nothing passes. Sample beats are registered once on the way out. Beats that are dropped leave the output valid low and the output data at zero.

Top module: `vbi_line_gate`

## Requirements
- R1: A write with address 0 loads the odd-field mask, and a write with address 1 loads the even-field mask. Each mask takes bits 23:0 of the write data, where bit n enables line n. Bits 31:24 of the write data are ignored, and writes to addresses 2 and 3 change nothing.
- R2: After reset both masks are all zeros, `pass_o` is 0 and `out_valid_o` is 0.
- R3: When `line_start_i` is high and direct mode is on, `pass_o` in the next cycle equals bit `line_idx_i` of the odd mask if `field_odd_i` is 1, and of the even mask if `field_odd_i` is 0.
- R4: A line-start strobe with `line_idx_i` of 24 or more gives `pass_o` = 0 in the next cycle, whatever the masks hold.
- R5: In any cycle with `direct_vbi_i` low, `pass_o` is 0 in the next cycle.
- R6: While direct mode stays on and no line-start strobe arrives, `pass_o` keeps its value.
- R7: The decision always uses the mask value from before any write made in the same cycle. A write made during a line, or in the line-start cycle itself, therefore affects only later lines.
- R8: `out_valid_o` is high in the cycle after a beat with `data_valid_i` high only if that beat's line passes. A beat that arrives in a line-start cycle is judged by that new line's decision.
- R9: When `out_valid_o` is high, `out_data_o` equals the `data_i` of the beat one cycle earlier. When `out_valid_o` is low, `out_data_o` is 0.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address (0 odd mask, 1 even mask) |
| reg_wdata_i | input | 32 | Register write data |
| direct_vbi_i | input | 1 | Direct-VBI mode enable |
| field_odd_i | input | 1 | Field parity, 1 = odd |
| line_start_i | input | 1 | Line-start strobe, qualifies index and parity |
| line_idx_i | input | 6 | VBI line index |
| data_valid_i | input | 1 | Input sample valid |
| data_i | input | 10 | Input sample |
| pass_o | output | 1 | Pass decision for the current line |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | 10 | Output sample, zero when not valid |

## Verification
A mask write and a line-start strobe can occur in the same cycle. So can a line-start strobe and a data beat. The random stimulus makes both collisions common by raising writes, strobes and beats independently. Directed cases also write a mask bit in the very cycle that starts the line which reads it. The bench model takes its decision from the masks as they stood before the edge, and it judges a beat in a start cycle by the new line's decision. Any ordering slip in the design shows up as a `pass_o` or `out_valid_o` mismatch.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;
  typedef enum logic [1:0] {
    ADDR_MASK_ODD  = 2'd0,
    ADDR_MASK_EVEN = 2'd1
  } vbi_reg_addr_e;
endpackage

// File: rtl/vbi_mask_bank.sv
module vbi_mask_bank #(
  parameter int NUM_LINES = 24,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [NUM_LINES-1:0] mask_odd_o,
  output logic [NUM_LINES-1:0] mask_even_o
);
  import vbi_gate_pkg::*;

  localparam int NUM_BANKS = 2;

  logic [NUM_LINES-1:0] mask_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] MY_ADDR =
      (g == 0) ? ADDR_W'(ADDR_MASK_ODD) : ADDR_W'(ADDR_MASK_EVEN);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mask_q[g] <= '0;
      else if (we_i && addr_i == MY_ADDR) mask_q[g] <= wdata_i[NUM_LINES-1:0];
    end
  end

  assign mask_odd_o  = mask_q[0];
  assign mask_even_o = mask_q[1];
endmodule

// File: rtl/vbi_pass_decide.sv
module vbi_pass_decide #(
  parameter int NUM_LINES = 24,
  parameter int IDX_W     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 direct_i,
  input  logic                 field_odd_i,
  input  logic                 line_start_i,
  input  logic [IDX_W-1:0]     line_idx_i,
  input  logic [NUM_LINES-1:0] mask_odd_i,
  input  logic [NUM_LINES-1:0] mask_even_i,
  output logic                 pass_eff_o,
  output logic                 pass_q_o
);
  logic [NUM_LINES-1:0] sel_mask;
  logic                 hit;
  logic                 pass_q;

  assign sel_mask = field_odd_i ? mask_odd_i : mask_even_i;

  // indices >= NUM_LINES match no bit
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (line_idx_i == IDX_W'(i)) hit = sel_mask[i];
    end
  end

  always_comb begin
    if (!direct_i)         pass_eff_o = 1'b0;
    else if (line_start_i) pass_eff_o = hit;
    else                   pass_eff_o = pass_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= 1'b0;
    else         pass_q <= pass_eff_o;
  end

  assign pass_q_o = pass_q;
endmodule

// File: rtl/vbi_stream_gate.sv
module vbi_stream_gate #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic keep;
  assign keep = valid_i & pass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= keep;
      data_o  <= keep ? data_i : '0;
    end
  end
endmodule

// File: rtl/vbi_line_gate.sv
module vbi_line_gate #(
  parameter int NUM_LINES = 24,
  parameter int IDX_W     = 6,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  input  logic              direct_vbi_i,
  input  logic              field_odd_i,
  input  logic              line_start_i,
  input  logic [IDX_W-1:0]  line_idx_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pass_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic [NUM_LINES-1:0] mask_odd, mask_even;
  logic                 pass_eff;

  vbi_mask_bank #(
    .NUM_LINES(NUM_LINES), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .mask_odd_o (mask_odd),
    .mask_even_o(mask_even)
  );

  vbi_pass_decide #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .direct_i    (direct_vbi_i),
    .field_odd_i (field_odd_i),
    .line_start_i(line_start_i),
    .line_idx_i  (line_idx_i),
    .mask_odd_i  (mask_odd),
    .mask_even_i (mask_even),
    .pass_eff_o  (pass_eff),
    .pass_q_o    (pass_o)
  );

  vbi_stream_gate #(
    .DATA_W(DATA_W)
  ) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pass_i (pass_eff),
    .valid_i(data_valid_i),
    .data_i (data_i),
    .valid_o(out_valid_o),
    .data_o (out_data_o)
  );
endmodule

// File: rtl/vbi_line_gate_chk.sv
module vbi_line_gate_chk #(
  parameter int NUM_LINES = 24,
  parameter int IDX_W     = 6,
  parameter int DATA_W    = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              direct_vbi_i,
  input logic              line_start_i,
  input logic [IDX_W-1:0]  line_idx_i,
  input logic              data_valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              pass_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o
);
  a_r4_high_index_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && line_idx_i >= IDX_W'(NUM_LINES)) |=> !pass_o);

  a_r5_mode_off_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !direct_vbi_i |=> !pass_o);

  a_r6_hold_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_vbi_i && !line_start_i) |=> $stable(pass_o));

  a_r8_blocked_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_o && !line_start_i) |=> !out_valid_o);

  a_r8_valid_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_i |=> !out_valid_o);

  a_r9_data_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i |=> (!out_valid_o || out_data_o == $past(data_i)));

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_data_o == '0);
endmodule

bind vbi_line_gate vbi_line_gate_chk #(
  .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .direct_vbi_i(direct_vbi_i),
  .line_start_i(line_start_i),
  .line_idx_i  (line_idx_i),
  .data_valid_i(data_valid_i),
  .data_i      (data_i),
  .pass_o      (pass_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/vbi_line_gate_test.sv
`timescale 1ns/1ps
module vbi_line_gate_test;
  localparam int NL = 24;
  localparam int IW = 6;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          direct = 1'b0;
  logic          fodd = 1'b0;
  logic          lstart = 1'b0;
  logic [IW-1:0] lidx = '0;
  logic          dv = 1'b0;
  logic [DW-1:0] din = '0;
  logic          pass_o, ov_o;
  logic [DW-1:0] od_o;

  always #2.5 clk = ~clk;

  vbi_line_gate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .direct_vbi_i(direct), .field_odd_i(fodd),
    .line_start_i(lstart), .line_idx_i(lidx),
    .data_valid_i(dv), .data_i(din),
    .pass_o(pass_o), .out_valid_o(ov_o), .out_data_o(od_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [NL-1:0] m_odd = '0, m_even = '0;
  logic          m_pass = 1'b0, m_ov = 1'b0;
  logic [DW-1:0] m_od = '0;

  function automatic logic lookup(logic [NL-1:0] mo, logic [NL-1:0] me,
                                  logic odd, logic [IW-1:0] idx);
    logic [NL-1:0] s = odd ? mo : me;
    if (idx >= IW'(NL)) return 1'b0;
    return s[idx];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply current inputs across one edge, advance model, compare at negedge
  task automatic step();
    logic eff;
    string ptag;
    if (!direct)                      ptag = "R5";
    else if (lstart && lidx >= IW'(NL)) ptag = "R4";
    else if (lstart && we)            ptag = "R7";
    else if (lstart)                  ptag = "R3";
    else                              ptag = "R6";
    eff = !direct ? 1'b0 : lstart ? lookup(m_odd, m_even, fodd, lidx) : m_pass;
    @(posedge clk);
    m_pass = eff;
    m_ov   = dv & eff;
    m_od   = (dv & eff) ? din : '0;
    if (we && addr == 2'd0) m_odd  = wdata[NL-1:0];
    if (we && addr == 2'd1) m_even = wdata[NL-1:0];
    @(negedge clk);
    check(ptag, 32'(pass_o), 32'(m_pass));
    check("R8", 32'(ov_o), 32'(m_ov));
    check("R9", 32'(od_o), 32'(m_od));
  endtask

  task automatic idle();
    we = 0; lstart = 0; dv = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    idle(); we = 1; addr = a; wdata = d; step(); idle();
  endtask

  task automatic start_line(logic odd, logic [IW-1:0] idx);
    idle(); lstart = 1; fodd = odd; lidx = idx; step(); idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", 32'(pass_o), 0);
    check("R2", 32'(ov_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    direct = 1;
    start_line(1, 6'd0);
    check("R2 odd mask zero", 32'(pass_o), 0);
    start_line(0, 6'd23);
    check("R2 even mask zero", 32'(pass_o), 0);

    // R1: reserved bits and unused addresses
    wr(2'd0, 32'hFF00_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      start_line(i[0], IW'(i));
      check("R1 no effect", 32'(pass_o), 0);
    end
    wr(2'd0, 32'h0080_0001);
    start_line(1, 6'd23);
    check("R1 odd bit23", 32'(pass_o), 1);
    start_line(0, 6'd23);
    check("R1 even untouched", 32'(pass_o), 0);
    wr(2'd1, 32'h00FF_FFFF);
    // R4: index beyond range with full masks
    start_line(0, 6'd24);
    check("R4 idx24", 32'(pass_o), 0);
    start_line(1, 6'd63);
    check("R4 idx63", 32'(pass_o), 0);

    // R7: write in the start cycle -> old mask decides
    wr(2'd1, 32'h0);
    idle(); lstart = 1; fodd = 0; lidx = 6'd5; we = 1; addr = 2'd1; wdata = 32'h20;
    step(); idle();
    check("R7 same-cycle write", 32'(pass_o), 0);
    start_line(0, 6'd5);
    check("R7 next line", 32'(pass_o), 1);
    wr(2'd1, 32'h0);
    check("R7 mid-line write", 32'(pass_o), 1);

    // R8: beat in start cycle judged by new line
    idle(); lstart = 1; fodd = 0; lidx = 6'd4; dv = 1; din = 10'h155;
    step(); idle();
    check("R8 start-cycle beat", 32'(ov_o), 0);

    // R5: mode off mid-line
    start_line(1, 6'd0);
    idle(); direct = 0; dv = 1; din = 10'h3AA; step(); idle();
    check("R5 mode off", 32'(pass_o), 0);
    direct = 1;

    // random mix
    for (int k = 0; k < 4000; k++) begin
      we     = ($urandom_range(0, 9) == 0);
      addr   = 2'($urandom_range(0, 3));
      wdata  = $urandom();
      direct = ($urandom_range(0, 9) != 0);
      lstart = ($urandom_range(0, 4) == 0);
      fodd   = 1'($urandom_range(0, 1));
      lidx   = IW'($urandom_range(0, 31));
      dv     = ($urandom_range(0, 2) != 0);
      din    = DW'($urandom());
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule